// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block decides who owns a shared system bus: an on-chip DMA engine, or the host processor together with any further masters hung off a grant chain. When the DMA engine asks for the bus, the block raises a bus request toward the host. When the host acknowledges, the block looks at a shared open-drain BUSY line. If that line is idle, it pulls the line low to claim the bus. Only then does it give the DMA engine its grant. When the engine reports that it has finished, the block lets go of BUSY, withdraws the request, and waits for the host to take its acknowledge back.

If an acknowledge arrives while the DMA engine is not asking for the bus, the block does not keep it. It passes the acknowledge on through an active-low chain output to the next master down the line. A mode input picks the pin polarity: either an active-high hold/hold-acknowledge pair, or an active-low request/acknowledge pair. A stop input forces every pin to its idle level.

Top module: `bus_grant_arbiter`

## Requirements
- R1: The bus request pin `breq_o` is active high when `hold_mode_i`=1 and active low when `hold_mode_i`=0. It is asserted from the cycle after a DMA request is seen in idle, and stays asserted until the engine reports done.
- R2: The acknowledge pin `back_i` means "granted" when it is 1 with `hold_mode_i`=1, and when it is 0 with `hold_mode_i`=0.
- R3: `back_i` and `busy_i` each pass through two flip-flops before the control logic uses them. A grant applied just before edge N therefore changes the outputs after edge N+2, not earlier.
- R4: The block claims BUSY (`busy_oe_o`=1, an open-drain pull-low) only after it has seen a grant together with a high BUSY line. While another master holds BUSY low, the block keeps requesting and does not drive BUSY. BUSY is never driven high.
- R5: `dma_grant_o` rises one cycle after `busy_oe_o` rises, never before.
- R6: A grant that is seen in idle with no DMA request drives the chain output `chain_n_o` low (0 = pass on).
- R7: After `chain_n_o` goes low, it stays low until the grant is withdrawn. A DMA request raised during that time does not assert `breq_o` until the grant is gone; a fresh request then follows.
- R8: A `dma_done_i` pulse while the bus is owned does three things on the next edge: it drops `busy_oe_o`, `dma_grant_o` and the request. The block then remains out of idle until the grant is withdrawn.
- R9: While `stop_i`=1, these pins are forced: `busy_oe_o`=0, `dma_grant_o`=0, `chain_n_o`=1, and `breq_o` inactive (0 when `hold_mode_i`=1, 1 when `hold_mode_i`=0). The controller returns to idle.
- R10: After reset, `busy_oe_o`=0, `dma_grant_o`=0, `chain_n_o`=1, and `breq_o` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_mode_i | input | 1 | 1: active-high request/acknowledge pins; 0: active-low pins |
| stop_i | input | 1 | Forces idle pin levels |
| dma_req_i | input | 1 | DMA engine wants the bus |
| dma_done_i | input | 1 | DMA engine finished; one-cycle pulse |
| dma_grant_o | output | 1 | DMA engine may start its transfer |
| breq_o | output | 1 | Bus request pin toward the host |
| back_i | input | 1 | Bus acknowledge pin from the host |
| busy_i | input | 1 | Sampled level of the shared BUSY line |
| busy_oe_o | output | 1 | Pull-low enable for the BUSY line |
| chain_n_o | output | 1 | Acknowledge passed down the chain, active low |

## Verification
The arbiter is run through four kinds of stimulus:
- A plain request, grant and done cycle in the active-low mode. This shows the claim, grant and release order.
- An acknowledge with no request pending. This separates pass-through from ownership and measures the synchronizer delay; a request raised during the pass then shows that it is held back until the grant is withdrawn.
- A request in the active-high mode while a foreign master holds BUSY low. This separates "granted" from "allowed to claim".
- Stop applied during a request and during a grant. This shows the forced pin levels in each polarity.

// File: rtl/bga_pkg.sv
package bga_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_CLAIM, ST_OWN, ST_DONE, ST_PASS
  } arb_state_t;

  // acknowledge pin level -> normalized grant
  function automatic logic grant_level(input logic hold_mode, input logic pin);
    return hold_mode ? pin : ~pin;
  endfunction

  // normalized request -> request pin level
  function automatic logic req_pin(input logic hold_mode, input logic active);
    return hold_mode ? active : ~active;
  endfunction
endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= rst_val_i;
          else        stg[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= rst_val_i;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bga_fsm.sv
module bga_fsm
  import bga_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic dma_req_i,
  input  logic dma_done_i,
  input  logic grant_s_i,
  input  logic busy_s_i,
  output logic req_act_o,
  output logic busy_oe_o,
  output logic pass_act_o,
  output logic dma_grant_o
);
  arb_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (stop_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (dma_req_i) st_d = ST_REQ;
                  else if (grant_s_i) st_d = ST_PASS;
        ST_REQ:   if (grant_s_i && busy_s_i) st_d = ST_CLAIM;
        ST_CLAIM: st_d = ST_OWN;
        ST_OWN:   if (dma_done_i) st_d = ST_DONE;
        ST_DONE:  if (!grant_s_i) st_d = ST_IDLE;
        ST_PASS:  if (!grant_s_i) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;

  wire hold_bus = (st_q == ST_CLAIM) || (st_q == ST_OWN);
  assign req_act_o   = !stop_i && (hold_bus || st_q == ST_REQ);
  assign busy_oe_o   = !stop_i && hold_bus;
  assign pass_act_o  = !stop_i && (st_q == ST_PASS);
  assign dma_grant_o = !stop_i && (st_q == ST_OWN);

  // R4
  claim_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_oe_o) |-> $past(grant_s_i && busy_s_i));
  // R5
  grant_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_grant_o) |-> $past(busy_oe_o));
  // R6
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_act_o && (busy_oe_o || req_act_o)));
  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || stop_i)
    (pass_act_o && grant_s_i) |=> pass_act_o);
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import bga_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_mode_i,
  input  logic stop_i,
  input  logic dma_req_i,
  input  logic dma_done_i,
  output logic dma_grant_o,
  output logic breq_o,
  input  logic back_i,
  input  logic busy_i,
  output logic busy_oe_o,
  output logic chain_n_o
);
  logic [1:0] raw_pins, sync_pins, idle_pins;
  logic grant_s, busy_s, req_act, pass_act;

  assign raw_pins  = {back_i, busy_i};
  assign idle_pins = {~hold_mode_i, 1'b1};

  bga_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_val_i(idle_pins),
    .d_i(raw_pins), .q_o(sync_pins)
  );

  assign grant_s = grant_level(hold_mode_i, sync_pins[1]);
  assign busy_s  = sync_pins[0];

  bga_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i),
    .dma_req_i(dma_req_i), .dma_done_i(dma_done_i),
    .grant_s_i(grant_s), .busy_s_i(busy_s),
    .req_act_o(req_act), .busy_oe_o(busy_oe_o),
    .pass_act_o(pass_act), .dma_grant_o(dma_grant_o)
  );

  assign breq_o    = req_pin(hold_mode_i, req_act);
  assign chain_n_o = ~pass_act;

  // R9
  stop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> (!busy_oe_o && chain_n_o && (breq_o == ~hold_mode_i)));
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n || stop_i)
    (dma_grant_o && dma_done_i) |=> (!busy_oe_o && !dma_grant_o && breq_o == ~hold_mode_i));
endmodule

// File: tb/test_bus_grant_arbiter.sv
module test_bus_grant_arbiter;
  logic clk = 0, rst_n = 0;
  logic hold_mode = 0, stop = 0, dma_req = 0, dma_done = 0;
  logic back = 1, other_busy = 0;
  logic dma_grant, breq, busy_oe, chain_n, busy_line;
  int checks = 0, fails = 0;
  bit ready = 0, finished = 0;
  logic [3:0] sb_q[$];

  always #2 clk = ~clk;
  assign busy_line = ~(busy_oe | other_busy);

  bus_grant_arbiter i_bus_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .hold_mode_i(hold_mode), .stop_i(stop),
    .dma_req_i(dma_req), .dma_done_i(dma_done), .dma_grant_o(dma_grant),
    .breq_o(breq), .back_i(back), .busy_i(busy_line),
    .busy_oe_o(busy_oe), .chain_n_o(chain_n)
  );

  function automatic logic [3:0] obs();
    logic req_on = hold_mode ? breq : ~breq;
    return {req_on, chain_n, busy_oe, dma_grant};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic expect_seq(input logic [3:0] v); sb_q.push_back(v); endtask
  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic after_edge(); @(posedge clk); #1; endtask

  // monitor: every change of {req, chain_n, busy_oe, grant} must match the next queued item
  initial begin
    logic [3:0] prev, cur;
    wait (ready);
    prev = obs();
    forever begin
      after_edge();
      cur = obs();
      if (cur !== prev) begin
        if (sb_q.size() == 0) check("R1 sequence (unexpected change)", cur, prev);
        else check("R4/R8 sequence", cur, sb_q.pop_front());
        prev = cur;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic done_pulse();
    dma_done = 1; dma_req = 0; cyc(1); dma_done = 0;
  endtask

  initial begin
    cyc(3);
    // R10 reset state, active-low mode
    check("R10", {breq, chain_n, busy_oe, dma_grant}, 4'b1100);
    rst_n = 1; cyc(1); ready = 1; cyc(1);

    // plain cycle, active-low pins (R1, R2, R4, R5, R8)
    expect_seq(4'b1100); dma_req = 1; cyc(5);
    check("R1 active-low request", {3'b0, breq}, 4'b0000);
    expect_seq(4'b1110); expect_seq(4'b1111); back = 0; cyc(8);
    check("R5 grant after claim", {3'b0, dma_grant}, 4'b0001);
    expect_seq(4'b0100); done_pulse(); cyc(3);
    check("R8 waits for grant removal", {3'b0, busy_oe}, 4'b0000);
    back = 1; cyc(6);

    // pass-through and synchronizer latency (R3, R6, R7)
    expect_seq(4'b0000);
    @(negedge clk); back = 0;
    after_edge(); check("R3 edge1", {3'b0, chain_n}, 4'b0001);
    after_edge(); check("R3 edge2", {3'b0, chain_n}, 4'b0001);
    after_edge(); check("R6 pass on edge3", {3'b0, chain_n}, 4'b0000);
    @(negedge clk); dma_req = 1; cyc(6);
    check("R7 request held during pass", {breq, chain_n, 2'b00}, 4'b1000);
    expect_seq(4'b0100); expect_seq(4'b1100); back = 1; cyc(6);
    check("R7 fresh request", {3'b0, breq}, 4'b0000);
    expect_seq(4'b1110); expect_seq(4'b1111); back = 0; cyc(8);
    expect_seq(4'b0100); done_pulse(); cyc(2); back = 1; cyc(6);

    // switch to active-high pins under stop
    stop = 1; cyc(1); hold_mode = 1; back = 0; cyc(4); stop = 0; cyc(2);
    check("R10 idle in hold mode", {breq, chain_n, 2'b00}, 4'b0100);

    // foreign master holds BUSY (R4, R1, R2)
    other_busy = 1;
    expect_seq(4'b1100); dma_req = 1; back = 1; cyc(10);
    check("R4 no claim while busy", {breq, busy_oe, 2'b00}, 4'b1000);
    expect_seq(4'b1110); expect_seq(4'b1111); other_busy = 0; cyc(8);
    check("R2 active-high grant owns bus", {busy_oe, dma_grant, 2'b00}, 4'b1100);
    expect_seq(4'b0100); done_pulse(); cyc(2); back = 0; cyc(6);

    // stop during request (R9)
    expect_seq(4'b1100); dma_req = 1; cyc(5);
    expect_seq(4'b0100); stop = 1; #1;
    check("R9 stop during request", {breq, chain_n, busy_oe, dma_grant}, 4'b0100);
    dma_req = 0; cyc(2); stop = 0; cyc(4);

    // stop during unrequested grant (R9, R6)
    stop = 1; back = 1; cyc(5);
    check("R9 chain held high", {3'b0, chain_n}, 4'b0001);
    expect_seq(4'b0000); stop = 0; cyc(6);
    check("R6 pass after stop", {3'b0, chain_n}, 4'b0000);
    expect_seq(4'b0100); back = 0; cyc(6);

    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R8 leftover expected items actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule